// File: doc/BRIEF.md
# Fixed-Point Temperature Compensation Unit

This unit turns a raw 20-bit temperature conversion result into a calibrated temperature in hundredths of a degree (a result of 2534 stands for 25.34 degrees). The calibration uses three factory trimming coefficients: one unsigned 16-bit offset and two signed 16-bit gains. Software or a bus engine streams the coefficients in as six bytes after reset. After that, the unit accepts one raw sample per cycle on a valid/ready input and runs the calibration polynomial in a four-stage pipeline. The polynomial uses signed 32-bit integer arithmetic only.

The result port carries the temperature and also the intermediate fine-temperature value. A later pressure compensation stage needs that fine value, so the unit exports it next to the temperature and it does not have to be computed again. The polynomial is reproduced to the bit, including the truncation points of each shift. Every product is truncated to 32 bits.

Top module: `tcomp_unit`

## Requirements
- R1: The coefficient stream holds six bytes. Each coefficient arrives low byte first, in the order T1, T2, T3. T1 is read as unsigned 16-bit. T2 and T3 are read as two's-complement 16-bit.
- R2: `smp_ready` is low from reset until the sixth coefficient byte is written. It goes high in the cycle after that write and stays high until the next reset.
- R3: A sample offered while `smp_ready` is low is not accepted and never produces a result.
- R4: While `smp_ready` is high, coefficient byte writes are ignored. Later results still use the coefficients loaded first.
- R5: The raw value is zero-extended to 32 bits. The first term is computed as follows:
  - take ((raw >>> 3) − (T1 << 1)) and multiply it by T2, keeping only the low 32 bits;
  - shift the product arithmetically right by 11.
- R6: The second term is computed in three steps:
  - let d = (raw >>> 4) − T1;
  - take d·d, keep the low 32 bits and shift arithmetically right by 12;
  - multiply by T3, keep the low 32 bits and shift arithmetically right by 14.
- R7: `res_fine` equals the sum of the two terms, wrapped to 32 bits.
- R8: `res_centi` equals (fine·5 + 128) shifted arithmetically right by 8, in 32-bit signed arithmetic.
- R9: Each accepted sample yields exactly one result. Results come out in acceptance order. `res_valid` is high for one cycle, and that cycle follows the fourth rising edge, counting the accepting edge as the first. Samples may be accepted on every cycle.
- R10: While `rst_n` is low, `res_valid` and `smp_ready` are low, all in-flight samples are dropped and the loaded coefficients are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cf_we | input | 1 | Coefficient byte write strobe |
| cf_byte | input | 8 | Coefficient byte |
| smp_valid | input | 1 | Raw sample valid |
| smp_ready | output | 1 | Unit can accept a sample |
| smp_raw | input | 20 | Raw temperature conversion result |
| res_valid | output | 1 | Result valid, one cycle per sample |
| res_centi | output | 32 | Temperature in 0.01 degree, signed |
| res_fine | output | 32 | Fine temperature for a later stage, signed |

## Verification
The case that is hardest to reach from the ports is 32-bit wraparound inside the polynomial. Ordinary coefficient values with mid-scale raw readings never overflow the squared difference or the products. To get there, the stimulus loads extreme coefficient sets, with T1 at full scale and T2 and T3 at the signed limits. It then offers raw values at zero and at full scale, values where the second-term difference vanishes, and long random streams. The stimulus also offers a sample in the same cycle as each coefficient byte, so acceptance is probed right at the sixth-byte boundary. It also writes stray coefficient bytes between samples and resets while samples are still in flight.

// File: rtl/tcomp_pkg.sv
package tcomp_pkg;
    localparam int ACC_W    = 32;
    localparam int PIPE_LAT = 4;
    // shift points of the calibration polynomial
    localparam int SH_D1    = 3;
    localparam int SH_D2    = 4;
    localparam int SH_P1    = 11;
    localparam int SH_SQ    = 12;
    localparam int SH_P2    = 14;
    localparam int OUT_MUL  = 5;
    localparam int OUT_RND  = 128;
    localparam int OUT_SH   = 8;

    typedef logic signed [ACC_W-1:0] acc_t;
endpackage

// File: rtl/tcomp_coef_load.sv
module tcomp_coef_load #(
    parameter int BYTE_W = 8,
    parameter int COEF_W = 16,
    parameter int N_COEF = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [BYTE_W-1:0]              byte_i,
    output logic                           loaded_o,
    output logic [N_COEF-1:0][COEF_W-1:0]  coef_o
);
    localparam int BPC    = COEF_W / BYTE_W;
    localparam int NBYTES = N_COEF * BPC;
    localparam int CNT_W  = $clog2(NBYTES + 1);

    typedef struct packed {
        logic [NBYTES-1:0][BYTE_W-1:0] bytes;
        logic [CNT_W-1:0]              cnt;
    } ld_t;

    ld_t ld_q, ld_d;

    assign loaded_o = (ld_q.cnt == CNT_W'(NBYTES));

    always_comb begin
        ld_d = ld_q;
        if (we && !loaded_o) begin
            ld_d.bytes[ld_q.cnt] = byte_i;
            ld_d.cnt             = ld_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ld_q <= '0;
        else        ld_q <= ld_d;
    end

    // byte 0 sits lowest, so each coefficient is a little-endian slice
    for (genvar k = 0; k < N_COEF; k++) begin : g_unpack
        assign coef_o[k] = ld_q.bytes[k*BPC +: BPC];
    end

    AST_COEF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        loaded_o |=> (loaded_o && $stable(coef_o)));                 // R4
    AST_LOAD_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loaded_o) |-> $past(we));                              // R2
endmodule

// File: rtl/tcomp_diff.sv
module tcomp_diff #(
    parameter int RAW_W  = 20,
    parameter int COEF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [RAW_W-1:0]  raw_i,
    input  logic [COEF_W-1:0] t1_i,
    output logic              out_vld,
    output tcomp_pkg::acc_t   d1_o,
    output tcomp_pkg::acc_t   d2_o
);
    import tcomp_pkg::*;

    typedef struct packed {
        logic vld;
        acc_t d1;
        acc_t d2;
    } st_t;

    st_t  st_q, st_d;
    acc_t raw_x, t1_x;

    always_comb begin
        raw_x = {{(ACC_W-RAW_W){1'b0}}, raw_i};
        t1_x  = {{(ACC_W-COEF_W){1'b0}}, t1_i};
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.d1 = (raw_x >>> SH_D1) - (t1_x <<< 1);
            st_d.d2 = (raw_x >>> SH_D2) - t1_x;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign d1_o    = st_q.d1;
    assign d2_o    = st_q.d2;
endmodule

// File: rtl/tcomp_poly.sv
module tcomp_poly #(
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  tcomp_pkg::acc_t          d1_i,
    input  tcomp_pkg::acc_t          d2_i,
    input  logic signed [COEF_W-1:0] t2_i,
    input  logic signed [COEF_W-1:0] t3_i,
    output logic                     out_vld,
    output tcomp_pkg::acc_t          fine_o
);
    import tcomp_pkg::*;

    typedef struct packed {
        logic vld;
        acc_t term1;
        acc_t sq;
    } sb_t;

    typedef struct packed {
        logic vld;
        acc_t fine;
    } sc_t;

    sb_t  sb_q, sb_d;
    sc_t  sc_q, sc_d;
    acc_t t2_x, t3_x, p1, p2, p3;

    always_comb begin
        t2_x = {{(ACC_W-COEF_W){t2_i[COEF_W-1]}}, t2_i};
        t3_x = {{(ACC_W-COEF_W){t3_i[COEF_W-1]}}, t3_i};
        // products keep only their low 32 bits
        p1 = d1_i * t2_x;
        p2 = d2_i * d2_i;
        p3 = sb_q.sq * t3_x;

        sb_d     = sb_q;
        sb_d.vld = in_vld;
        if (in_vld) begin
            sb_d.term1 = p1 >>> SH_P1;
            sb_d.sq    = p2 >>> SH_SQ;
        end

        sc_d     = sc_q;
        sc_d.vld = sb_q.vld;
        if (sb_q.vld) begin
            sc_d.fine = sb_q.term1 + (p3 >>> SH_P2);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sb_q <= '0;
            sc_q <= '0;
        end else begin
            sb_q <= sb_d;
            sc_q <= sc_d;
        end
    end

    assign out_vld = sc_q.vld;
    assign fine_o  = sc_q.fine;

    AST_SQ_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && d2_i > -32'sd46341 && d2_i < 32'sd46341) |=> !sb_q.sq[ACC_W-1]); // R6
endmodule

// File: rtl/tcomp_scale.sv
module tcomp_scale (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  tcomp_pkg::acc_t fine_i,
    output logic            out_vld,
    output tcomp_pkg::acc_t centi_o,
    output tcomp_pkg::acc_t fine_o
);
    import tcomp_pkg::*;

    typedef struct packed {
        logic vld;
        acc_t centi;
        acc_t fine;
    } sd_t;

    sd_t sd_q, sd_d;

    always_comb begin
        sd_d     = sd_q;
        sd_d.vld = in_vld;
        if (in_vld) begin
            sd_d.fine  = fine_i;
            sd_d.centi = (fine_i * OUT_MUL + OUT_RND) >>> OUT_SH;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sd_q <= '0;
        else        sd_q <= sd_d;
    end

    assign out_vld = sd_q.vld;
    assign centi_o = sd_q.centi;
    assign fine_o  = sd_q.fine;

    AST_RES_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> !$isunknown({centi_o, fine_o}));                 // R8
endmodule

// File: rtl/tcomp_unit.sv
module tcomp_unit #(
    parameter int RAW_W  = 20,
    parameter int BYTE_W = 8,
    parameter int COEF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cf_we,
    input  logic [BYTE_W-1:0] cf_byte,
    input  logic              smp_valid,
    output logic              smp_ready,
    input  logic [RAW_W-1:0]  smp_raw,
    output logic              res_valid,
    output logic signed [31:0] res_centi,
    output logic signed [31:0] res_fine
);
    import tcomp_pkg::*;

    localparam int N_COEF = 3;

    logic                          loaded;
    logic [N_COEF-1:0][COEF_W-1:0] coef;
    logic                          accept;
    logic                          a_vld, c_vld;
    acc_t                          d1, d2, fine_c, centi, fine_d;

    tcomp_coef_load #(.BYTE_W(BYTE_W), .COEF_W(COEF_W), .N_COEF(N_COEF)) u_load (
        .clk(clk), .rst_n(rst_n), .we(cf_we), .byte_i(cf_byte),
        .loaded_o(loaded), .coef_o(coef)
    );

    assign smp_ready = loaded;
    assign accept    = smp_valid && smp_ready;

    tcomp_diff #(.RAW_W(RAW_W), .COEF_W(COEF_W)) u_diff (
        .clk(clk), .rst_n(rst_n), .in_vld(accept), .raw_i(smp_raw),
        .t1_i(coef[0]), .out_vld(a_vld), .d1_o(d1), .d2_o(d2)
    );

    tcomp_poly #(.COEF_W(COEF_W)) u_poly (
        .clk(clk), .rst_n(rst_n), .in_vld(a_vld), .d1_i(d1), .d2_i(d2),
        .t2_i(coef[1]), .t3_i(coef[2]), .out_vld(c_vld), .fine_o(fine_c)
    );

    tcomp_scale u_scale (
        .clk(clk), .rst_n(rst_n), .in_vld(c_vld), .fine_i(fine_c),
        .out_vld(res_valid), .centi_o(centi), .fine_o(fine_d)
    );

    assign res_centi = centi;
    assign res_fine  = fine_d;

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(smp_valid && smp_ready, 4));              // R9
    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |=> smp_ready);                                    // R2
endmodule

// File: tb/sim_tcomp_unit.sv
module sim_tcomp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cf_we = 1'b0;
    logic [7:0]  cf_byte = '0;
    logic        smp_valid = 1'b0;
    logic        smp_ready;
    logic [19:0] smp_raw = '0;
    logic        res_valid;
    logic signed [31:0] res_centi, res_fine;

    always #10 clk = ~clk;   // 50 MHz

    tcomp_unit u0 (
        .clk(clk), .rst_n(rst_n), .cf_we(cf_we), .cf_byte(cf_byte),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_raw(smp_raw),
        .res_valid(res_valid), .res_centi(res_centi), .res_fine(res_fine)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int bw     = 0;
    int c1, c2, c3;
    int q_fine[$], q_centi[$], q_cyc[$];

    // R5 R6 R7 R8: independent integer model of the polynomial
    function automatic void model(input int raw, input int t1, input int t2, input int t3,
                                  output int fine, output int centi);
        int a, b, s;
        a = (((raw >>> 3) - (t1 <<< 1)) * t2) >>> 11;
        s = (raw >>> 4) - t1;
        b = (((s * s) >>> 12) * t3) >>> 14;
        fine  = a + b;
        centi = (fine * 5 + 128) >>> 8;
    endfunction

    task automatic observe();
        if (res_valid) begin
            checks++;
            if (q_cyc.size() == 0) begin
                fails++;
                $display("FAIL R3 R9 unexpected result: actual valid=1 expected valid=0");
            end else begin
                int ef, ec, et;
                ef = q_fine.pop_front(); ec = q_centi.pop_front(); et = q_cyc.pop_front();
                if (et != cyc) begin
                    fails++;
                    $display("FAIL R9 latency: actual cycle %0d expected %0d", cyc, et);
                end
                checks++;
                if (res_fine != ef) begin
                    fails++;
                    $display("FAIL R1 R5 R6 R7 fine: actual %0d expected %0d", res_fine, ef);
                end
                checks++;
                if (res_centi != ec) begin
                    fails++;
                    $display("FAIL R8 centi: actual %0d expected %0d", res_centi, ec);
                end
            end
        end else if (q_cyc.size() != 0 && q_cyc[0] <= cyc) begin
            checks++; fails++;
            $display("FAIL R9 missing result: actual valid=0 expected valid=1");
            void'(q_fine.pop_front()); void'(q_centi.pop_front()); void'(q_cyc.pop_front());
        end
    endtask

    task automatic tick(input logic v, input logic [19:0] raw, input logic we, input logic [7:0] b);
        @(negedge clk);
        cyc++;
        observe();
        checks++;
        if (smp_ready !== (bw >= 6)) begin
            fails++;
            $display("FAIL R2 ready: actual %0b expected %0b", smp_ready, (bw >= 6));
        end
        smp_valid = v; smp_raw = raw; cf_we = we; cf_byte = b;
        if (v && bw >= 6) begin
            int f, c;
            model(int'(raw), c1, c2, c3, f, c);
            q_fine.push_back(f); q_centi.push_back(c); q_cyc.push_back(cyc + 4);
        end
        if (we && bw < 6) bw++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; smp_valid = 1'b0; cf_we = 1'b0;
        q_fine.delete(); q_centi.delete(); q_cyc.delete();
        bw = 0;
        repeat (2) @(negedge clk);
        checks++;
        if (smp_ready !== 1'b0 || res_valid !== 1'b0) begin
            fails++;
            $display("FAIL R10 reset: actual ready=%0b valid=%0b expected 0 0", smp_ready, res_valid);
        end
        rst_n = 1'b1;
    endtask

    // R1: low byte first, T1 then T2 then T3; a sample is offered with each byte (R3)
    task automatic load(input int t1, input int t2, input int t3);
        logic [7:0] bs [6];
        c1 = t1 & 16'hFFFF;
        c2 = int'(shortint'(t2));
        c3 = int'(shortint'(t3));
        bs[0] = c1[7:0]; bs[1] = c1[15:8];
        bs[2] = c2[7:0]; bs[3] = c2[15:8];
        bs[4] = c3[7:0]; bs[5] = c3[15:8];
        for (int i = 0; i < 6; i++) tick(1'b1, 20'($urandom), 1'b1, bs[i]);
    endtask

    task automatic directed();
        tick(1'b1, 20'd0, 1'b0, 8'h00);
        tick(1'b1, 20'hFFFFF, 1'b0, 8'h00);
        tick(1'b1, 20'(c1 * 16), 1'b0, 8'h00);        // second-term difference zero
        tick(1'b1, 20'(c1 * 8), 1'b0, 8'h00);
        tick(1'b1, 20'd519888, 1'b0, 8'h00);
        tick(1'b0, 20'd0, 1'b0, 8'h00);
        tick(1'b1, 20'd1, 1'b0, 8'h00);
    endtask

    // R4: stray byte writes while loaded must leave results unchanged
    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            logic v, w;
            v = ($urandom % 10) < 7;
            w = ($urandom % 10) == 0;
            tick(v, 20'($urandom), w, 8'($urandom));
        end
        repeat (6) tick(1'b0, 20'd0, 1'b0, 8'h00);
    endtask

    initial begin
        void'($urandom(32'h5eed_7c01));
        do_reset();
        // R3: samples before any coefficient are refused
        repeat (3) tick(1'b1, 20'($urandom), 1'b0, 8'h00);
        repeat (5) tick(1'b0, 20'd0, 1'b0, 8'h00);
        load(27504, 26435, -1000);
        directed();
        random_run(400);
        // reset with samples in flight (R10)
        repeat (3) tick(1'b1, 20'($urandom), 1'b0, 8'h00);
        do_reset();
        repeat (6) tick(1'b0, 20'd0, 1'b0, 8'h00);
        load(65535, -32768, 32767);
        directed();
        random_run(400);
        do_reset();
        load(-1, 32767, -32768);
        directed();
        random_run(200);
        do_reset();
        load(int'($urandom % 65536), int'($urandom), int'($urandom));
        directed();
        random_run(400);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule